// File: doc/BRIEF.md
# Cascaded Triple Timer with Interrupts

The block holds three 16-bit down counters behind one byte-wide register port. Counter 2 is a programmable prescaler. It decrements on every cycle in which the master tick enable is high. Each time it reaches terminal count, it produces a one-cycle pulse, and that pulse is the only enable that counters 0 and 1 ever see. Counters 0 and 1 each set a sticky interrupt flag when they reach terminal count. Software lowers a flag in one of two ways: it writes ones to a clear register, or it reads an acknowledge address.

Software sets up each counter in two steps. First it writes a control byte that names the counter and its mode. Then it writes the 16-bit reload value as two bytes, low byte first. A counter runs in one of two modes. In rate-generator mode it reloads itself at terminal count and repeats. In strobe mode it stays stopped. To read a stable count, software first issues a latch command and then makes two byte reads, low byte then high byte. The smallest reload the rate generator supports is 2.

Top module: `cascade_timer`

## Requirements
- R1: After reset both interrupt outputs are low, every counter is stopped and reads as zero.
- R2: The control byte at address 3 holds the counter select in bits [7:6] (0..2; 3 is ignored), the access field in bits [5:4] (00 = latch command, any other value = program), and the mode in bits [3:1]. A program command stops the counter. The counter then waits for its reload: the low byte and then the high byte written to data address 0, 1 or 2. It holds its count until the high byte arrives, loads the count on that write, and decrements on the first enable after it.
- R3: With mode 3'b010 (rate generator) and reload N, a counter reaches terminal count once every N enables. On the terminal-count enable it reloads N instead of decrementing.
- R4: Counter 2 is enabled by the tick input. Counters 0 and 1 change only on cycles where counter 2 reaches terminal count, or when their own reload is written.
- R5: A reload value of 0 is loaded as a count of zero, which stands for 65536 enables. The first enable after loading moves the count to 0xFFFF.
- R6: A latch command freezes the selected counter's count at that edge. Further latch commands are ignored until the frozen value is read out. The next two reads of that counter return the low byte and then the high byte of the frozen value, while the counter keeps running.
- R7: When no latch is pending, reads of a counter's data address return the live count, alternating low byte then high byte. A program command resets the read order to low.
- R8: Any mode other than 3'b010 (strobe) keeps the counter stopped, with its count held, even after its reload is written.
- R9: Terminal count of counter 0 or counter 1 sets irq0 or irq1 on the following edge. The flag stays high until it is cleared.
- R10: A write to address 4 clears irq0 when data bit 0 is set and irq1 when data bit 1 is set. Zero bits have no effect. A terminal count in the same cycle wins over the clear.
- R11: A read of address 5 returns irq0 in bit 0 and clears it. A read of address 6 returns irq1 in bit 0 and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Master clock enable for counter 2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects at the edge) |
| addr | input | 3 | Register address: 0..2 data, 3 control, 4 clear, 5/6 acknowledge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq0 | output | 1 | Counter 0 interrupt flag |
| irq1 | output | 1 | Counter 1 interrupt flag |

## Verification
The cascade is tested first with a steady tick and prescale 4. With the reloads 3 and 5 below it, the flags should first rise after 12 and 20 ticks; a wrong link between the stages or an off-by-one would move those times. A random tick pattern with random clears, acknowledges and reads then runs against a behavioural model on every clock. This separates gating by counter 2's terminal count from gating by the raw tick. Directed patterns cover the rest: a pending low byte with no high byte yet, a reload of zero, a latch while the counter runs, and a stopped strobe counter. Each has expected bytes worked out in advance, so a latch that stays frozen is told apart from a live read, and wraparound from 0 is told apart from a stop.

// File: rtl/cascade_timer.sv
module cascade_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq0,
  output logic       irq1
);
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_CLR  = 3'd4;
  localparam logic [2:0] A_ACK0 = 3'd5;
  localparam logic [2:0] A_ACK1 = 3'd6;
  localparam logic [2:0] MODE_RATE = 3'b010;

  logic [15:0] cnt [3];
  logic [15:0] rl  [3];
  logic [15:0] lat [3];
  logic [7:0]  lo_hold [3];
  logic [2:0]  latched, rd_hi, wr_hi, run, rate;
  logic [2:0]  tc, en;
  logic [15:0] src;

  wire [1:0] sel      = wdata[7:6];
  wire       ctrl_wr  = wr_en && addr == A_CTRL && sel != 2'd3;
  wire       latch_cmd = ctrl_wr && wdata[5:4] == 2'b00;
  wire       prog_cmd  = ctrl_wr && wdata[5:4] != 2'b00;

  assign tc[2] = run[2] && tick_en && cnt[2] == 16'd1;
  assign tc[0] = run[0] && tc[2] && cnt[0] == 16'd1;
  assign tc[1] = run[1] && tc[2] && cnt[1] == 16'd1;
  assign en    = {tick_en, tc[2], tc[2]};

  wire clr0 = (wr_en && addr == A_CLR && wdata[0]) || (rd_en && addr == A_ACK0);
  wire clr1 = (wr_en && addr == A_CLR && wdata[1]) || (rd_en && addr == A_ACK1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        cnt[i] <= '0;
        rl[i] <= '0;
        lat[i] <= '0;
        lo_hold[i] <= '0;
      end
      latched <= '0;
      rd_hi <= '0;
      wr_hi <= '0;
      run <= '0;
      rate <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (run[i] && en[i])
          cnt[i] <= (cnt[i] == 16'd1) ? rl[i] : cnt[i] - 16'd1;
        if (wr_en && addr == 3'(i)) begin
          if (!wr_hi[i]) begin
            lo_hold[i] <= wdata;
            wr_hi[i] <= 1'b1;
          end else begin
            rl[i] <= {wdata, lo_hold[i]};
            cnt[i] <= {wdata, lo_hold[i]};
            run[i] <= rate[i];
            wr_hi[i] <= 1'b0;
          end
        end
        if (prog_cmd && sel == 2'(i)) begin
          rate[i] <= wdata[3:1] == MODE_RATE;
          run[i] <= 1'b0;
          wr_hi[i] <= 1'b0;
          rd_hi[i] <= 1'b0;
          latched[i] <= 1'b0;
        end
        if (latch_cmd && sel == 2'(i) && !latched[i]) begin
          lat[i] <= cnt[i];
          latched[i] <= 1'b1;
        end
        if (rd_en && addr == 3'(i)) begin
          rd_hi[i] <= !rd_hi[i];
          if (rd_hi[i]) latched[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      if (clr0) irq0 <= 1'b0;
      if (tc[0]) irq0 <= 1'b1;
      if (clr1) irq1 <= 1'b0;
      if (tc[1]) irq1 <= 1'b1;
    end
  end

  always_comb begin
    src = '0;
    rdata = '0;
    case (addr)
      3'd0, 3'd1, 3'd2: begin
        src = latched[addr[1:0]] ? lat[addr[1:0]] : cnt[addr[1:0]];
        rdata = rd_hi[addr[1:0]] ? src[15:8] : src[7:0];
      end
      A_ACK0: rdata = {7'd0, irq0};
      A_ACK1: rdata = {7'd0, irq1};
      default: rdata = '0;
    endcase
  end

  assert_cascade_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc[2] && !(wr_en && addr == 3'd0)) |=> $stable(cnt[0]));
  assert_strobe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[2] && !(wr_en && addr == 3'd2)) |=> $stable(cnt[2]));
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tc[2] && !wr_en) |=> cnt[2] == $past(rl[2]));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 && !clr0) |=> irq0);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR && wdata[1] && !tc[1]) |=> !irq1);
  assert_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ACK0 && !tc[0]) |=> !irq0);
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latched[2] && !(rd_en && addr == 3'd2) && !prog_cmd) |=> $stable(lat[2]));
endmodule

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb;
  logic clk = 0, rst_n = 0, tick_en = 1, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq0, irq1;
  int checks = 0, errors = 0;
  bit tick_rand = 0, done = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  cascade_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq0(irq0), .irq1(irq1));

  int m_cnt[3], m_rl[3], m_lat[3];
  bit m_latched[3], m_rdhi[3], m_wrhi[3], m_run[3], m_rate[3];
  logic [7:0] m_lo[3];
  bit m_f0, m_f1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 65536; m_rl[i] = 65536; m_lat[i] = 0; m_lo[i] = 0;
        m_latched[i] = 0; m_rdhi[i] = 0; m_wrhi[i] = 0; m_run[i] = 0; m_rate[i] = 0;
      end
      m_f0 = 0; m_f1 = 0;
    end else begin
      bit t2, t0, t1;
      int s, a, v;
      t2 = m_run[2] && tick_en && m_cnt[2] == 1;
      t0 = m_run[0] && t2 && m_cnt[0] == 1;
      t1 = m_run[1] && t2 && m_cnt[1] == 1;
      s = wdata[7:6];
      a = addr;
      if (wr_en && a == 3 && s != 3 && wdata[5:4] == 0 && !m_latched[s]) begin
        m_lat[s] = m_cnt[s] & 16'hFFFF; m_latched[s] = 1;
      end
      if (rd_en && a < 3) begin
        if (m_rdhi[a]) m_latched[a] = 0;
        m_rdhi[a] = !m_rdhi[a];
      end
      if (m_run[2] && tick_en) m_cnt[2] = (m_cnt[2] == 1) ? m_rl[2] : m_cnt[2] - 1;
      for (int i = 0; i < 2; i++)
        if (m_run[i] && t2) m_cnt[i] = (m_cnt[i] == 1) ? m_rl[i] : m_cnt[i] - 1;
      if (wr_en && a < 3) begin
        if (!m_wrhi[a]) begin
          m_lo[a] = wdata; m_wrhi[a] = 1;
        end else begin
          v = {wdata, m_lo[a]};
          m_rl[a] = (v == 0) ? 65536 : v;
          m_cnt[a] = m_rl[a];
          m_run[a] = m_rate[a];
          m_wrhi[a] = 0;
        end
      end
      if (wr_en && a == 3 && s != 3 && wdata[5:4] != 0) begin
        m_rate[s] = (wdata[3:1] == 3'b010);
        m_run[s] = 0; m_wrhi[s] = 0; m_rdhi[s] = 0; m_latched[s] = 0;
      end
      if ((wr_en && a == 4 && wdata[0]) || (rd_en && a == 5)) m_f0 = 0;
      if ((wr_en && a == 4 && wdata[1]) || (rd_en && a == 6)) m_f1 = 0;
      if (t0) m_f0 = 1;
      if (t1) m_f1 = 1;
    end
  end

  function automatic int exp_rd(input int a);
    int v;
    if (a < 3) begin
      v = m_latched[a] ? m_lat[a] : (m_cnt[a] & 16'hFFFF);
      return m_rdhi[a] ? ((v >> 8) & 8'hFF) : (v & 8'hFF);
    end
    if (a == 5) return int'(m_f0);
    if (a == 6) return int'(m_f1);
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    tick_en = tick_rand ? 1'($urandom % 2) : 1'b1;
    #1;
    got = rdata;
    check(irq0 == m_f0, "R9 irq0 vs model", int'(irq0), int'(m_f0));
    check(irq1 == m_f1, "R9 irq1 vs model", int'(irq1), int'(m_f1));
    check(int'(rdata) == exp_rd(int'(a)), "R7 rdata vs model", int'(rdata), exp_rd(int'(a)));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 3'd7, 8'h00);
  endtask

  task automatic prog(input logic [1:0] c, input logic [2:0] mode, input logic [15:0] v);
    cyc(1, 0, 3'd3, {c, 2'b11, mode, 1'b0});
    cyc(1, 0, {1'b0, c}, v[7:0]);
    cyc(1, 0, {1'b0, c}, v[15:8]);
  endtask

  localparam logic [2:0] RATE = 3'b010, STROBE = 3'b100;

  initial begin
    int first0, first1;
    logic [7:0] a0, a1, b0, b1;
    idle(3);
    rst_n = 1;
    cyc(0, 0, 3'd0, 0);
    check(irq0 == 0 && irq1 == 0, "R1 irq after reset", {irq1, irq0}, 0);
    check(got == 0, "R1 count after reset", got, 0);

    prog(0, RATE, 16'd3);
    prog(1, RATE, 16'd5);
    prog(2, RATE, 16'd4);
    first0 = 0; first1 = 0;
    for (int k = 1; k <= 30; k++) begin
      cyc(0, 0, 3'd7, 0);
      if (irq0 && first0 == 0) first0 = k;
      if (irq1 && first1 == 0) first1 = k;
    end
    check(first0 == 13, "R3 R4 counter0 first terminal count", first0, 13);
    check(first1 == 21, "R3 R4 counter1 first terminal count", first1, 21);

    cyc(1, 0, 3'd3, 8'hB8);
    cyc(1, 0, 3'd4, 8'h03);
    cyc(0, 0, 3'd7, 0);
    check(irq0 == 0 && irq1 == 0, "R10 clear both", {irq1, irq0}, 0);

    cyc(1, 0, 3'd3, 8'hB4);
    cyc(1, 0, 3'd2, 8'h02);
    idle(20);
    check(irq0 == 0 && irq1 == 0, "R2 held until high byte", {irq1, irq0}, 0);
    cyc(1, 0, 3'd2, 8'h00);
    idle(30);
    check(irq0 == 1 && irq1 == 1, "R2 R9 running after high byte", {irq1, irq0}, 3);
    cyc(1, 0, 3'd3, 8'hB8);
    idle(3);
    check(irq0 == 1 && irq1 == 1, "R9 sticky flags", {irq1, irq0}, 3);
    cyc(1, 0, 3'd4, 8'h02);
    cyc(0, 0, 3'd7, 0);
    check(irq1 == 0 && irq0 == 1, "R10 selective clear", {irq1, irq0}, 1);
    cyc(0, 1, 3'd5, 0);
    check(got == 8'h01, "R11 ack read value", got, 1);
    cyc(0, 0, 3'd7, 0);
    check(irq0 == 0, "R11 ack clears irq0", irq0, 0);

    cyc(0, 1, 3'd2, 0); a0 = got;
    cyc(0, 1, 3'd2, 0); a1 = got;
    idle(5);
    cyc(0, 1, 3'd2, 0); b0 = got;
    cyc(0, 1, 3'd2, 0); b1 = got;
    check({a1, a0} == {b1, b0}, "R8 stopped counter holds", {b1, b0}, {a1, a0});
    prog(1, STROBE, 16'hABCD);
    idle(4);
    cyc(0, 1, 3'd1, 0);
    check(got == 8'hCD, "R7 R8 live low byte", got, 8'hCD);
    cyc(0, 1, 3'd1, 0);
    check(got == 8'hAB, "R7 R8 live high byte", got, 8'hAB);

    prog(2, RATE, 16'h0300);
    cyc(1, 0, 3'd3, 8'h80);
    idle(5);
    cyc(0, 1, 3'd2, 0);
    check(got == 8'h00, "R6 latched low byte", got, 8'h00);
    cyc(0, 1, 3'd2, 0);
    check(got == 8'h03, "R6 latched high byte", got, 8'h03);
    cyc(0, 1, 3'd2, 0);
    check(got == 8'hF8, "R7 live low after latch", got, 8'hF8);
    cyc(0, 1, 3'd2, 0);
    check(got == 8'h02, "R7 live high after latch", got, 8'h02);

    prog(2, RATE, 16'h0000);
    cyc(0, 1, 3'd2, 0);
    check(got == 8'h00, "R5 zero reload loaded", got, 8'h00);
    cyc(0, 1, 3'd2, 0);
    check(got == 8'hFF, "R5 wrap to FFFF", got, 8'hFF);
    cyc(1, 0, 3'd3, 8'h80);
    cyc(0, 1, 3'd2, 0);
    check(got == 8'hFE, "R6 latch after wrap", got, 8'hFE);
    cyc(0, 1, 3'd2, 0);

    tick_rand = 1;
    prog(0, RATE, 16'd2);
    prog(1, RATE, 16'd3);
    prog(2, RATE, 16'd2);
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom % 8;
      if (r == 0) cyc(1, 0, 3'd4, 8'($urandom % 4));
      else if (r == 1) cyc(0, 1, 3'($urandom % 7), 0);
      else if (r == 2) cyc(1, 0, 3'd3, {2'($urandom % 3), 6'b000000});
      else cyc(0, 0, 3'd7, 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule